// File: doc/BRIEF.md
# ATA Task-File Register Front End

This block sits between a host register bus and the state machine of an ATA disk device. The host reaches it through two register windows: the command block (data port, error/features, sector count, sector number, cylinder low, cylinder high, drive/head, status/command) and the control block (alternate status on read, device control on write). The block decodes each access and keeps the task-file fields. It reports each access that the device state machine must react to as a one-cycle action pulse.

The data port is one 16-bit word. A 32-bit access to it becomes two word transfers in sequence: low half first, then high half, with one data action each. Status comes in from the state machine. Reading it through the command block raises a status-read action, while reading it through the control window has no side effect. A device-control write drives the soft-reset handshake and refreshes the interrupt-disable bit. Illegal offsets and access sizes finish at once with an error indication and change nothing.

Top module: `taskfile_regs`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), every task-file field, `tf_data` and `nien` are zero, and `act_pulse`, `acc_ready` and `acc_err` are low.
- R2: A data-port write (command block, offset 0) with size code 1 (16 bits) stores `acc_wdata[15:0]` in `tf_data`. In the cycle after acceptance it raises only `act_pulse[1]` (data write) together with `acc_ready`.
- R3: A data-port read with size code 1 returns the `dev_rdata` value present at acceptance in `acc_rdata[15:0]`, with upper bits zero. In the cycle after acceptance it raises only `act_pulse[0]` (data read) together with `acc_ready`.
- R4: A data-port write with size code 2 (32 bits) raises `act_pulse[1]` in two consecutive cycles. `tf_data` holds `acc_wdata[15:0]` in the first and `acc_wdata[31:16]` in the second, and `acc_ready` rises only with the second.
- R5: A data-port read with size code 2 takes the low half from `dev_rdata` at acceptance and raises `act_pulse[0]`. It raises `act_pulse[0]` again in the next cycle, then takes the high half from `dev_rdata` one cycle later, when `acc_ready` rises.
- R6: A data-port access with size code 0 or 3 sets `acc_err` with `acc_ready`, raises no action and leaves `tf_data` unchanged.
- R7: Command-block offsets 2 to 6 (count, sector, cylinder low, cylinder high, drive/head) accept byte writes (size code 0) that read back unchanged, and a read of offset 1 returns `dev_error`. Any size other than 0 at offsets 1 to 7 is an error.
- R8: A byte read of command-block offset 7 returns `dev_status` and raises `act_pulse[2]`. A byte read of control-block offset 6 returns `dev_status` with no action.
- R9: A byte write to offset 6 stores the value in `tf_drive` and raises `act_pulse[3]`. A byte write to offset 7 stores it in `tf_command` and raises `act_pulse[4]`.
- R10: A byte write to offset 1 (features) completes without error, raises no action and changes no field.
- R11: A control-block write to offset 6 with bit 2 set raises `act_pulse[5]`. With bit 2 clear it raises `act_pulse[6]` only when `dev_in_srst` is high at acceptance.
- R12: Every control-block write to offset 6 copies `acc_wdata[1]` into `nien`, and nothing else changes `nien`.
- R13: A control-block access to any offset other than 6, or of size other than 0, sets `acc_err` and changes no state.
- R14: While a 32-bit data transfer is in progress, `acc_valid` is ignored, and the ignored access changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ctrl | input | 1 | 1 = control block, 0 = command block |
| acc_offset | input | 3 | Register offset in the block |
| acc_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access complete pulse |
| acc_err | output | 1 | Access was illegal (valid with acc_ready) |
| acc_rdata | output | 32 | Read data (valid with acc_ready) |
| dev_status | input | 8 | Device status from the state machine |
| dev_error | input | 8 | Error register value from the state machine |
| dev_rdata | input | 16 | Current data word from the state machine |
| dev_in_srst | input | 1 | Device is in soft reset |
| act_pulse | output | 7 | Action pulses: 0 data rd, 1 data wr, 2 status rd, 3 select, 4 command, 5 srst set, 6 srst clear |
| tf_data | output | 16 | Last word written to the data port |
| tf_count | output | 8 | Sector count field |
| tf_sector | output | 8 | Sector number field |
| tf_cyl_lo | output | 8 | Cylinder low field |
| tf_cyl_hi | output | 8 | Cylinder high field |
| tf_drive | output | 8 | Drive/head field |
| tf_command | output | 8 | Last command opcode |
| nien | output | 1 | Interrupt-disable bit |

## Verification
The bench builds the block with its defaults: a 16-bit data word, byte-wide task-file fields and a 32-bit host bus. With these values a 32-bit access is exactly two words, so both split sequences can be reached, including the extra cycle a split read needs. The bench's device model advances its data word on every data-read pulse, so a wrong half order or a wrong sample cycle shows up as a wrong word. Back-to-back status reads, an access issued inside a split, and a second reset after the fields are loaded are all part of the run.

// File: rtl/taskfile_pkg.sv
// Shared types and constants for the task-file register front end.
// Assumes offsets fit in three bits; bit positions in the control byte
// and command-block offsets are fixed by the host protocol.
package taskfile_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int ACT_N  = 7;
    localparam int A_DRD  = 0;
    localparam int A_DWR  = 1;
    localparam int A_STAT = 2;
    localparam int A_SEL  = 3;
    localparam int A_CMD  = 4;
    localparam int A_RSET = 5;
    localparam int A_RCLR = 6;

    localparam logic [2:0] OFF_DATA    = 3'd0;
    localparam logic [2:0] OFF_ERRFEAT = 3'd1;
    localparam logic [2:0] OFF_DRIVE   = 3'd6;
    localparam logic [2:0] OFF_STATCMD = 3'd7;
    localparam logic [2:0] OFF_CTRL    = 3'd6;

    typedef enum logic [3:0] {
        OP_BAD,
        OP_DATA_RD,
        OP_DATA_WR,
        OP_ERR_RD,
        OP_FEAT_WR,
        OP_FIELD_RD,
        OP_FIELD_WR,
        OP_STAT_RD,
        OP_ALT_RD,
        OP_CTRL_WR
    } op_e;

    typedef struct packed {
        op_e        op;
        logic       split;
        logic [2:0] idx;
    } dec_t;

endpackage

// File: rtl/tf_decode.sv
// Access decoder: classifies one host access into an operation.
// Purely combinational; assumes the caller only uses the result when
// a request is accepted.
module tf_decode
    import taskfile_pkg::*;
(
    input  logic      ctrl_i,
    input  logic      wr_i,
    input  logic [2:0] off_i,
    input  acc_size_e size_i,
    output dec_t      dec_o
);

    // Map block, offset, direction and size onto an operation code.
    always_comb begin
        dec_o.op    = OP_BAD;
        dec_o.split = 1'b0;
        dec_o.idx   = off_i;
        if (ctrl_i) begin
            if (off_i == OFF_CTRL && size_i == SZ_BYTE)
                dec_o.op = wr_i ? OP_CTRL_WR : OP_ALT_RD;
        end else if (off_i == OFF_DATA) begin
            if (size_i == SZ_HALF || size_i == SZ_WORD) begin
                dec_o.op    = wr_i ? OP_DATA_WR : OP_DATA_RD;
                dec_o.split = (size_i == SZ_WORD);
            end
        end else if (size_i == SZ_BYTE) begin
            if (off_i == OFF_ERRFEAT)
                dec_o.op = wr_i ? OP_FEAT_WR : OP_ERR_RD;
            else if (off_i == OFF_STATCMD)
                dec_o.op = wr_i ? OP_FIELD_WR : OP_STAT_RD;
            else
                dec_o.op = wr_i ? OP_FIELD_WR : OP_FIELD_RD;
        end
    end

endmodule

// File: rtl/tf_fields.sv
// Task-file storage: byte fields at offsets 2..7, the data word and the
// interrupt-disable bit. Assumes at most one byte write per cycle;
// unused indices 0 and 1 read as zero.
module tf_fields #(
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 16,
    parameter int FIRST_IX = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_we,
    input  logic [2:0]             byte_idx,
    input  logic [BYTE_W-1:0]      byte_wd,
    input  logic                   word_we,
    input  logic [WORD_W-1:0]      word_wd,
    input  logic                   ctl_we,
    input  logic                   ctl_bit,
    output logic [7:0][BYTE_W-1:0] bytes_o,
    output logic [WORD_W-1:0]      word_o,
    output logic                   nien_o
);

    localparam int SLOTS = 8;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < FIRST_IX) begin : g_none
            assign bytes_o[g] = '0;
        end else begin : g_reg
            // Hold one task-file byte, loaded when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bytes_o[g] <= '0;
                else if (byte_we && byte_idx == 3'(g))
                    bytes_o[g] <= byte_wd;
            end
        end
    end

    // Hold the data-port word written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_o <= '0;
        else if (word_we)
            word_o <= word_wd;
    end

    // Hold the interrupt-disable bit from device-control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nien_o <= 1'b0;
        else if (ctl_we)
            nien_o <= ctl_bit;
    end

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_we |=> $stable(bytes_o)); // R10
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_we |=> $stable(word_o)); // R6
    AST_NIEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(nien_o)); // R12

endmodule

// File: rtl/taskfile_regs.sv
// Task-file register front end. Accepts one access per request while
// idle, answers with a one-cycle acc_ready, and emits one-cycle action
// pulses. Assumes the device state machine advances dev_rdata on the
// clock edge that ends a data-read pulse.
module taskfile_regs
    import taskfile_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int SRST_BIT = 2,
    parameter int NIEN_BIT = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_ctrl,
    input  logic [2:0]          acc_offset,
    input  logic [1:0]          acc_size,
    input  logic [2*WORD_W-1:0] acc_wdata,
    output logic                acc_ready,
    output logic                acc_err,
    output logic [2*WORD_W-1:0] acc_rdata,
    input  logic [BYTE_W-1:0]   dev_status,
    input  logic [BYTE_W-1:0]   dev_error,
    input  logic [WORD_W-1:0]   dev_rdata,
    input  logic                dev_in_srst,
    output logic [ACT_N-1:0]    act_pulse,
    output logic [WORD_W-1:0]   tf_data,
    output logic [BYTE_W-1:0]   tf_count,
    output logic [BYTE_W-1:0]   tf_sector,
    output logic [BYTE_W-1:0]   tf_cyl_lo,
    output logic [BYTE_W-1:0]   tf_cyl_hi,
    output logic [BYTE_W-1:0]   tf_drive,
    output logic [BYTE_W-1:0]   tf_command,
    output logic                nien
);

    localparam int BUS_W = 2 * WORD_W;

    typedef enum logic [1:0] {PH_IDLE, PH_SECOND, PH_HIGH} phase_e;

    phase_e                    phase;
    logic                      split_wr;
    logic [WORD_W-1:0]         hi_word;
    dec_t                      dec;
    logic                      accept;
    logic [7:0][BYTE_W-1:0]    fields;
    logic                      byte_we, word_we, ctl_we;
    logic [WORD_W-1:0]         word_wd;

    tf_decode u_decode (
        .ctrl_i (acc_ctrl),
        .wr_i   (acc_write),
        .off_i  (acc_offset),
        .size_i (acc_size_e'(acc_size)),
        .dec_o  (dec)
    );

    // Write enables into the field store for this cycle.
    always_comb begin
        accept  = acc_valid && (phase == PH_IDLE);
        byte_we = accept && (dec.op == OP_FIELD_WR);
        ctl_we  = accept && (dec.op == OP_CTRL_WR);
        word_we = (accept && dec.op == OP_DATA_WR) || (phase == PH_SECOND && split_wr);
        word_wd = (phase == PH_SECOND) ? hi_word : acc_wdata[WORD_W-1:0];
    end

    tf_fields #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_we  (byte_we),
        .byte_idx (dec.idx),
        .byte_wd  (acc_wdata[BYTE_W-1:0]),
        .word_we  (word_we),
        .word_wd  (word_wd),
        .ctl_we   (ctl_we),
        .ctl_bit  (acc_wdata[NIEN_BIT]),
        .bytes_o  (fields),
        .word_o   (tf_data),
        .nien_o   (nien)
    );

    assign tf_count   = fields[2];
    assign tf_sector  = fields[3];
    assign tf_cyl_lo  = fields[4];
    assign tf_cyl_hi  = fields[5];
    assign tf_drive   = fields[6];
    assign tf_command = fields[7];

    // Sequence accesses, split 32-bit data transfers and raise actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            split_wr  <= 1'b0;
            hi_word   <= '0;
            act_pulse <= '0;
            acc_ready <= 1'b0;
            acc_err   <= 1'b0;
            acc_rdata <= '0;
        end else begin
            act_pulse <= '0;
            acc_ready <= 1'b0;
            acc_err   <= 1'b0;
            case (phase)
                PH_IDLE: if (acc_valid) begin
                    case (dec.op)
                        OP_DATA_RD: begin
                            act_pulse[A_DRD] <= 1'b1;
                            acc_rdata        <= BUS_W'(dev_rdata);
                            split_wr         <= 1'b0;
                            if (dec.split) phase <= PH_SECOND;
                            else           acc_ready <= 1'b1;
                        end
                        OP_DATA_WR: begin
                            act_pulse[A_DWR] <= 1'b1;
                            hi_word          <= acc_wdata[BUS_W-1:WORD_W];
                            split_wr         <= 1'b1;
                            if (dec.split) phase <= PH_SECOND;
                            else           acc_ready <= 1'b1;
                        end
                        OP_ERR_RD: begin
                            acc_rdata <= BUS_W'(dev_error);
                            acc_ready <= 1'b1;
                        end
                        OP_FEAT_WR: acc_ready <= 1'b1;
                        OP_FIELD_RD: begin
                            acc_rdata <= BUS_W'(fields[dec.idx]);
                            acc_ready <= 1'b1;
                        end
                        OP_FIELD_WR: begin
                            acc_ready        <= 1'b1;
                            act_pulse[A_SEL] <= (dec.idx == OFF_DRIVE);
                            act_pulse[A_CMD] <= (dec.idx == OFF_STATCMD);
                        end
                        OP_STAT_RD: begin
                            acc_rdata         <= BUS_W'(dev_status);
                            act_pulse[A_STAT] <= 1'b1;
                            acc_ready         <= 1'b1;
                        end
                        OP_ALT_RD: begin
                            acc_rdata <= BUS_W'(dev_status);
                            acc_ready <= 1'b1;
                        end
                        OP_CTRL_WR: begin
                            acc_ready <= 1'b1;
                            if (acc_wdata[SRST_BIT])
                                act_pulse[A_RSET] <= 1'b1;
                            else if (dev_in_srst)
                                act_pulse[A_RCLR] <= 1'b1;
                        end
                        default: begin
                            acc_ready <= 1'b1;
                            acc_err   <= 1'b1;
                        end
                    endcase
                end
                PH_SECOND: begin
                    if (split_wr) begin
                        act_pulse[A_DWR] <= 1'b1;
                        acc_ready        <= 1'b1;
                        phase            <= PH_IDLE;
                    end else begin
                        act_pulse[A_DRD] <= 1'b1;
                        phase            <= PH_HIGH;
                    end
                end
                default: begin
                    acc_rdata[BUS_W-1:WORD_W] <= dev_rdata;
                    acc_ready                 <= 1'b1;
                    phase                     <= PH_IDLE;
                end
            endcase
        end
    end

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (act_pulse == '0)); // R6
    AST_ERR_READY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_ready); // R13
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_pulse)); // R2
    AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SECOND) |=> (act_pulse[A_DRD] || act_pulse[A_DWR])); // R4
    AST_HIGH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH) |=> acc_ready); // R5
    AST_CLR_NEEDS_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse[A_RCLR] |-> $past(dev_in_srst)); // R11
    AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> !act_pulse[A_SEL] && !act_pulse[A_CMD]); // R14

endmodule

// File: tb/taskfile_regs_tb.sv
module taskfile_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_ctrl = 1'b0;
    logic [2:0]  acc_offset = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready, acc_err;
    logic [31:0] acc_rdata;
    logic [7:0]  dev_status = 8'h58, dev_error = 8'h04;
    logic [15:0] dev_rdata = 16'hA5C3;
    logic        dev_in_srst = 1'b0;
    logic [6:0]  act_pulse;
    logic [15:0] tf_data;
    logic [7:0]  tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi, tf_drive, tf_command;
    logic        nien;

    always #10 clk = ~clk;

    taskfile_regs u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_ctrl(acc_ctrl), .acc_offset(acc_offset), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .acc_ready(acc_ready), .acc_err(acc_err),
        .acc_rdata(acc_rdata), .dev_status(dev_status), .dev_error(dev_error),
        .dev_rdata(dev_rdata), .dev_in_srst(dev_in_srst), .act_pulse(act_pulse),
        .tf_data(tf_data), .tf_count(tf_count), .tf_sector(tf_sector),
        .tf_cyl_lo(tf_cyl_lo), .tf_cyl_hi(tf_cyl_hi), .tf_drive(tf_drive),
        .tf_command(tf_command), .nien(nien)
    );

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // Behavioural reference model, updated on every rising edge.
    logic [6:0]  m_act = '0;
    logic        m_ready = 1'b0, m_err = 1'b0, m_nien = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [15:0] m_data = '0, m_hi = '0;
    logic [7:0]  m_f [8];
    int          m_phase = 0;
    bit          m_wr = 1'b0;

    always @(posedge clk) begin
        logic [6:0] prev;
        bit ok;
        prev = m_act;
        if (!rst_n) begin
            m_act = '0; m_ready = 0; m_err = 0; m_nien = 0; m_data = '0;
            m_phase = 0; m_rdata = '0;
            for (int i = 0; i < 8; i++) m_f[i] = '0;
        end else begin
            m_act = '0; m_ready = 0; m_err = 0;
            if (m_phase == 1) begin
                if (m_wr) begin
                    m_data = m_hi; m_act[1] = 1; m_ready = 1; m_phase = 0;
                end else begin
                    m_act[0] = 1; m_phase = 2;
                end
            end else if (m_phase == 2) begin
                m_rdata[31:16] = dev_rdata; m_ready = 1; m_phase = 0;
            end else if (acc_valid) begin
                if (acc_ctrl)
                    ok = (acc_offset == 6) && (acc_size == 0);
                else if (acc_offset == 0)
                    ok = (acc_size == 1) || (acc_size == 2);
                else
                    ok = (acc_size == 0);
                if (!ok) begin
                    m_ready = 1; m_err = 1;
                end else if (acc_ctrl) begin
                    m_ready = 1;
                    if (acc_write) begin
                        m_nien = acc_wdata[1];
                        if (acc_wdata[2]) m_act[5] = 1;
                        else if (dev_in_srst) m_act[6] = 1;
                    end else
                        m_rdata = {24'h0, dev_status};
                end else if (acc_offset == 0) begin
                    if (acc_write) begin
                        m_data = acc_wdata[15:0]; m_act[1] = 1;
                        m_hi = acc_wdata[31:16]; m_wr = 1;
                    end else begin
                        m_rdata = {16'h0, dev_rdata}; m_act[0] = 1; m_wr = 0;
                    end
                    if (acc_size == 2) m_phase = 1; else m_ready = 1;
                end else begin
                    m_ready = 1;
                    if (acc_write) begin
                        if (acc_offset != 1) m_f[acc_offset] = acc_wdata[7:0];
                        if (acc_offset == 6) m_act[3] = 1;
                        if (acc_offset == 7) m_act[4] = 1;
                    end else if (acc_offset == 1)
                        m_rdata = {24'h0, dev_error};
                    else if (acc_offset == 7) begin
                        m_rdata = {24'h0, dev_status}; m_act[2] = 1;
                    end else
                        m_rdata = {24'h0, m_f[acc_offset]};
                end
            end
            // Fake device: the data word advances after each data-read pulse.
            if (prev[0]) dev_rdata <= dev_rdata + 16'h1357;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, a, e);
        end
    endtask

    // Compare every output against the model between clock edges.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(act_pulse === m_act, "act_pulse", 32'(act_pulse), 32'(m_act));
            chk(acc_ready === m_ready, "acc_ready", 32'(acc_ready), 32'(m_ready));
            chk(acc_err === m_err, "acc_err", 32'(acc_err), 32'(m_err));
            if (m_ready && !m_err)
                chk(acc_rdata === m_rdata, "acc_rdata", acc_rdata, m_rdata);
            chk(tf_data === m_data, "tf_data", 32'(tf_data), 32'(m_data));
            chk(tf_count === m_f[2], "tf_count", 32'(tf_count), 32'(m_f[2]));
            chk(tf_sector === m_f[3], "tf_sector", 32'(tf_sector), 32'(m_f[3]));
            chk(tf_cyl_lo === m_f[4], "tf_cyl_lo", 32'(tf_cyl_lo), 32'(m_f[4]));
            chk(tf_cyl_hi === m_f[5], "tf_cyl_hi", 32'(tf_cyl_hi), 32'(m_f[5]));
            chk(tf_drive === m_f[6], "tf_drive", 32'(tf_drive), 32'(m_f[6]));
            chk(tf_command === m_f[7], "tf_command", 32'(tf_command), 32'(m_f[7]));
            chk(nien === m_nien, "nien", 32'(nien), 32'(m_nien));
        end
    end

    // One access, issued at a falling edge, followed by idle cycles.
    task automatic acc(input bit c, input bit w, input logic [2:0] o,
                       input logic [1:0] s, input logic [31:0] d, input string t);
        tag = t;
        acc_ctrl = c; acc_write = w; acc_offset = o; acc_size = s;
        acc_wdata = d; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        acc(0, 1, 2, 0, 32'h12, "R7");
        acc(0, 1, 3, 0, 32'h34, "R7");
        acc(0, 1, 4, 0, 32'h56, "R7");
        acc(0, 1, 5, 0, 32'h78, "R7");
        acc(0, 0, 2, 0, 0, "R7");
        acc(0, 0, 5, 0, 0, "R7");
        acc(0, 0, 1, 0, 0, "R7");
        acc(0, 1, 3, 1, 32'hFF, "R7");
        acc(0, 0, 7, 2, 0, "R7");
        acc(1, 0, 3, 0, 0, "R13");
        acc(1, 1, 0, 0, 32'h06, "R13");
        acc(1, 1, 6, 1, 32'h06, "R13");
        acc(0, 1, 6, 0, 32'hE0, "R9");
        acc(0, 0, 6, 0, 0, "R9");
        acc(0, 1, 7, 0, 32'hEC, "R9");
        acc(0, 1, 1, 0, 32'hFF, "R10");
        acc(0, 0, 7, 0, 0, "R8");
        acc(1, 0, 6, 0, 0, "R8");
        // back-to-back status reads
        tag = "R8";
        acc_ctrl = 0; acc_write = 0; acc_offset = 7; acc_size = 0; acc_valid = 1;
        @(negedge clk);
        dev_status = 8'hD0;
        @(negedge clk);
        acc_valid = 0;
        repeat (3) @(negedge clk);
        acc(0, 1, 0, 1, 32'h0000BEEF, "R2");
        acc(0, 0, 0, 1, 0, "R3");
        acc(0, 0, 0, 1, 0, "R3");
        acc(0, 1, 0, 2, 32'h12345678, "R4");
        acc(0, 0, 0, 2, 0, "R5");
        acc(0, 1, 0, 0, 32'h1111, "R6");
        acc(0, 1, 0, 3, 32'h2222, "R6");
        acc(0, 0, 0, 0, 0, "R6");
        acc(0, 0, 0, 3, 0, "R6");
        acc(1, 1, 6, 0, 32'h04, "R11");
        dev_in_srst = 1'b1;
        acc(1, 1, 6, 0, 32'h00, "R11");
        dev_in_srst = 1'b0;
        acc(1, 1, 6, 0, 32'h00, "R11");
        acc(1, 1, 6, 0, 32'h02, "R12");
        acc(1, 1, 6, 0, 32'h06, "R12");
        acc(1, 1, 6, 0, 32'h00, "R12");
        // request while a split write is in progress is ignored
        tag = "R14";
        acc_ctrl = 0; acc_write = 1; acc_offset = 0; acc_size = 2;
        acc_wdata = 32'hCAFE_F00D; acc_valid = 1;
        @(negedge clk);
        acc_offset = 2; acc_size = 0; acc_wdata = 32'h99;
        @(negedge clk);
        acc_valid = 0;
        repeat (3) @(negedge clk);
        acc(0, 0, 0, 2, 0, "R14");
        // second reset with loaded fields
        tag = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule